// File: doc/BRIEF.md
# Video Input Loss Detector

This block watches a captured video stream and flags when the stream is no longer valid. Four checks run side by side, and each has its own enable bit. The runaway check catches a line that goes on too long. The vertical check catches a frame with the wrong number of lines, and also a write address that climbs past a programmed ceiling. The line-data check catches a line whose count of valid samples differs from a reference line. The clock-loss check catches a video pixel clock that has stopped. The first three checks run in the video clock domain. Their events cross into the system clock domain as toggles, and there they set sticky pending bits.

The clock-loss check is a watchdog in the system clock domain. The video domain flips an activity toggle on every video clock. Each synchronized transition of that toggle restarts the watchdog counter. The video clock must be slower than the system clock so that every transition is seen. `video_ok` is high only while no pending bit is set. Software clears the pending bits with a write-one-to-clear strobe. `irq` reports the pending bits whose checks are enabled.

Top module: `video_loss_monitor`

## Requirements
- R1: After reset, `pend` is 0, `video_ok` is 1, `irq` is 0 and `line_abort` is 0.
- R2: Line lengths are counted in video clocks, and the clock that carries `vid_line_start` counts as clock 1. If a line reaches clock RUNAWAY_LIMIT+1 (3001 by default) with no new line start, `pend[0]` is set and `line_abort` goes high until the next line start. A line of exactly RUNAWAY_LIMIT clocks raises no fault.
- R3: On each `vid_frame_start` after the first, the number of line starts since the previous frame start is compared with `exp_lines`; the frame-start line counts as one. Any difference sets `pend[1]`.
- R4: When `wr_addr` changes from not greater than `max_addr` to greater than it, `pend[1]` is set. An address equal to `max_addr` raises no fault.
- R5: The count of `vid_valid` clocks in the first complete line after a frame start becomes the reference. Each later line that closes with a different count sets `pend[2]`. Lines aborted under R2 are neither compared nor used as the reference.
- R6: If CLK_LOSS_LIMIT (128) system clocks pass with no video clock activity, `pend[3]` is set. The bit is set again on every system clock while the video clock stays absent.
- R7: A check whose `chk_en` bit is 0 (bit 0 runaway, 1 vertical/address, 2 line data, 3 clock loss) never sets its pending bit. With `chk_en[0]` at 0, no line is aborted.
- R8: `video_ok` is low whenever any pending bit is set, and it goes high only once every pending bit has been cleared.
- R9: A system clock with `clr_we` high clears each pending bit whose `clr_data` bit is 1. If a set event hits the same bit in the same clock, the set wins.
- R10: `irq` is the OR of the pending bits whose enable bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System clock; runs the pending logic and the watchdog |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| vid_clk | input | 1 | Video pixel clock |
| chk_en | input | 4 | Check enables: 0 runaway, 1 vertical/address, 2 line data, 3 clock loss |
| vid_valid | input | 1 | Active sample on this video clock |
| vid_line_start | input | 1 | First clock of a line |
| vid_frame_start | input | 1 | First clock of a frame; asserted together with `vid_line_start` |
| exp_lines | input | LINE_W | Expected lines per frame |
| max_addr | input | ADDR_W | Highest legal write address |
| wr_addr | input | ADDR_W | Current capture write address |
| clr_we | input | 1 | Clear strobe for the pending bits |
| clr_data | input | 4 | Pending bits to clear (1 clears) |
| pend | output | 4 | Sticky pending bits, same bit order as `chk_en` |
| irq | output | 1 | Interrupt: enabled pending bits ORed together |
| video_ok | output | 1 | High while no pending bit is set |
| line_abort | output | 1 | Video domain: current line aborted as runaway |

## Verification
A pending bit can be set and cleared in the same system clock. To force this, the bench stops the video clock so that the watchdog reasserts `pend[3]` on every cycle, then issues a clear of that bit. The set must win: the bit stays high, and `video_ok` and `irq` stay at their fault values. A second collision is two pending bits set at once. Clearing one of them must leave `video_ok` low, and only the second clear may bring it back high.

// File: rtl/video_loss_monitor.sv
module video_loss_monitor #(
  parameter int RUNAWAY_LIMIT  = 3000,
  parameter int CLK_LOSS_LIMIT = 128,
  parameter int LINE_W         = 11,
  parameter int ADDR_W         = 16
) (
  input  logic              sys_clk,
  input  logic              rst_n,
  input  logic              vid_clk,
  input  logic [3:0]        chk_en,
  input  logic              vid_valid,
  input  logic              vid_line_start,
  input  logic              vid_frame_start,
  input  logic [LINE_W-1:0] exp_lines,
  input  logic [ADDR_W-1:0] max_addr,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              clr_we,
  input  logic [3:0]        clr_data,
  output logic [3:0]        pend,
  output logic              irq,
  output logic              video_ok,
  output logic              line_abort
);

  localparam int PW = $clog2(RUNAWAY_LIMIT + 2);
  localparam int WW = $clog2(CLK_LOSS_LIMIT + 1);
  localparam logic [PW-1:0] RUN_HIT = PW'(RUNAWAY_LIMIT);
  localparam logic [PW-1:0] RUN_SAT = PW'(RUNAWAY_LIMIT + 1);
  localparam logic [WW-1:0] WD_MAX  = WW'(CLK_LOSS_LIMIT);

  // ---------------- video clock domain ----------------
  logic [PW-1:0]     clk_cnt, act_cnt, ref_cnt;
  logic              have_ref, line_open, frame_seen, addr_over_q, tgl_a;
  logic [LINE_W-1:0] line_cnt;
  logic [2:0]        tgl_v;

  wire addr_over = wr_addr > max_addr;
  wire run_hit   = line_open && !line_abort && !vid_line_start && (clk_cnt == RUN_HIT);
  wire closing   = vid_line_start && line_open && !line_abort;
  wire mis_ev    = closing && have_ref && (act_cnt != ref_cnt);
  wire vert_ev   = (vid_frame_start && frame_seen && (line_cnt != exp_lines)) ||
                   (addr_over && !addr_over_q);

  always_ff @(posedge vid_clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_cnt     <= '0;
      act_cnt     <= '0;
      ref_cnt     <= '0;
      have_ref    <= 1'b0;
      line_open   <= 1'b0;
      line_abort  <= 1'b0;
      frame_seen  <= 1'b0;
      line_cnt    <= '0;
      addr_over_q <= 1'b0;
      tgl_v       <= '0;
      tgl_a       <= 1'b0;
    end else begin
      tgl_a       <= ~tgl_a;
      tgl_v       <= tgl_v ^ {mis_ev, vert_ev, run_hit};
      addr_over_q <= addr_over;
      if (vid_line_start) begin
        clk_cnt    <= {{(PW-1){1'b0}}, 1'b1};
        act_cnt    <= {{(PW-1){1'b0}}, vid_valid};
        line_abort <= 1'b0;
        line_open  <= 1'b1;
      end else begin
        if (line_open && clk_cnt != RUN_SAT) clk_cnt <= clk_cnt + 1'b1;
        if (run_hit && chk_en[0]) line_abort <= 1'b1;
        if (vid_valid && line_open && !line_abort && !(&act_cnt)) act_cnt <= act_cnt + 1'b1;
      end
      if (vid_frame_start) begin
        have_ref <= 1'b0;
      end else if (closing && !have_ref) begin
        ref_cnt  <= act_cnt;
        have_ref <= 1'b1;
      end
      if (vid_frame_start) begin
        line_cnt   <= {{(LINE_W-1){1'b0}}, 1'b1};
        frame_seen <= 1'b1;
      end else if (vid_line_start && !(&line_cnt)) begin
        line_cnt <= line_cnt + 1'b1;
      end
    end
  end

  AST_ABORT_NEEDS_EN: assert property (@(posedge vid_clk) disable iff (!rst_n)
    $rose(line_abort) |-> $past(chk_en[0]));  // R7
  AST_LINE_CNT_BOUND: assert property (@(posedge vid_clk) disable iff (!rst_n)
    clk_cnt <= RUN_SAT);  // R2

  // ---------------- system clock domain ----------------
  logic [3:0]    s1, s2, s3;
  logic [WW-1:0] wd_cnt;

  wire [3:0] edg     = s2 ^ s3;
  wire       stalled = wd_cnt == WD_MAX;
  wire [3:0] set_v   = {stalled, edg[2:0]} & chk_en;
  wire [3:0] clr_v   = clr_we ? clr_data : 4'b0;

  always_ff @(posedge sys_clk or negedge rst_n) begin
    if (!rst_n) begin
      s1     <= '0;
      s2     <= '0;
      s3     <= '0;
      wd_cnt <= '0;
      pend   <= '0;
    end else begin
      s1   <= {tgl_a, tgl_v};
      s2   <= s1;
      s3   <= s2;
      pend <= (pend & ~clr_v) | set_v;
      if (edg[3])       wd_cnt <= '0;
      else if (!stalled) wd_cnt <= wd_cnt + 1'b1;
    end
  end

  assign irq      = |(pend & chk_en);
  assign video_ok = ~|pend;

  AST_PEND_NEEDS_EN: assert property (@(posedge sys_clk) disable iff (!rst_n)
    (pend & ~$past(pend) & ~$past(chk_en)) == 4'b0);  // R7
  AST_CLEAR_TAKES: assert property (@(posedge sys_clk) disable iff (!rst_n)
    clr_we |=> ((pend & $past(clr_data & ~set_v)) == 4'b0));  // R9
  AST_OK_NEEDS_CLEAR: assert property (@(posedge sys_clk) disable iff (!rst_n)
    $rose(video_ok) |-> $past(clr_we));  // R8
  AST_IRQ_QUIET_WHEN_OK: assert property (@(posedge sys_clk) disable iff (!rst_n)
    video_ok |-> !irq);  // R10
  AST_LOSS_AFTER_WINDOW: assert property (@(posedge sys_clk) disable iff (!rst_n)
    $rose(pend[3]) |-> ($past(wd_cnt) == WD_MAX));  // R6

endmodule

// File: tb/video_loss_monitor_test.sv
module video_loss_monitor_test;
  logic        sys_clk = 1'b0, vid_clk = 1'b0, rst_n = 1'b0, vid_run = 1'b1;
  logic [3:0]  chk_en = 4'hF, clr_data = 4'h0;
  logic        clr_we = 1'b0, vid_valid = 1'b0, vid_line_start = 1'b0, vid_frame_start = 1'b0;
  logic [10:0] exp_lines = 11'd4;
  logic [15:0] max_addr = 16'd100, wr_addr = 16'd0;
  logic [3:0]  pend;
  logic        irq, video_ok, line_abort;
  int checks = 0, errors = 0;

  video_loss_monitor uut (
    .sys_clk(sys_clk), .rst_n(rst_n), .vid_clk(vid_clk), .chk_en(chk_en),
    .vid_valid(vid_valid), .vid_line_start(vid_line_start), .vid_frame_start(vid_frame_start),
    .exp_lines(exp_lines), .max_addr(max_addr), .wr_addr(wr_addr),
    .clr_we(clr_we), .clr_data(clr_data), .pend(pend), .irq(irq),
    .video_ok(video_ok), .line_abort(line_abort));

  always #2 sys_clk = ~sys_clk;
  always #5 vid_clk = vid_run ? ~vid_clk : 1'b0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_sys(int n);
    repeat (n) @(negedge sys_clk);
  endtask

  task automatic clear(logic [3:0] m);
    @(negedge sys_clk); clr_we = 1'b1; clr_data = m;
    @(negedge sys_clk); clr_we = 1'b0; clr_data = 4'h0;
  endtask

  task automatic vid_line(int len, int nvalid, bit fs);
    @(negedge vid_clk);
    vid_line_start = 1'b1; vid_frame_start = fs; vid_valid = (nvalid > 0);
    for (int i = 1; i < len; i++) begin
      @(negedge vid_clk);
      vid_line_start = 1'b0; vid_frame_start = 1'b0; vid_valid = (i < nvalid);
    end
  endtask

  task automatic resync();
    vid_line(20, 10, 1);
    repeat (3) vid_line(20, 10, 0);
    wait_sys(12);
    clear(4'hF);
  endtask

  task automatic runaway(int len, logic [3:0] en, bit exp_hit);
    chk_en = en;
    resync();
    vid_line(20, 10, 1);
    vid_line(len, 10, 0);
    @(posedge vid_clk); #1;
    chk("R2 line_abort", {31'd0, line_abort}, {31'd0, exp_hit});
    vid_line(20, 10, 0);
    vid_line(20, 10, 0);
    vid_line(20, 10, 1);
    wait_sys(12);
    chk(en[0] ? "R2 runaway pend" : "R7 runaway disabled", {28'd0, pend}, {31'd0, exp_hit});
    chk_en = 4'hF;
  endtask

  initial begin
    #800000;
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait_sys(3);
    chk("R1 pend", {28'd0, pend}, 0);
    chk("R1 video_ok", {31'd0, video_ok}, 1);
    chk("R1 irq", {31'd0, irq}, 0);
    chk("R1 line_abort", {31'd0, line_abort}, 0);
    @(negedge sys_clk); rst_n = 1'b1;
    wait_sys(4);

    // R3: sweep lines per frame around exp_lines = 4
    for (int n = 2; n <= 6; n++) begin
      resync();
      vid_line(20, 10, 1);
      repeat (n - 1) vid_line(20, 10, 0);
      vid_line(20, 10, 1);
      wait_sys(12);
      chk("R3 vertical count", {28'd0, pend}, (n != 4) ? 32'h2 : 32'h0);
      chk("R8 video_ok vertical", {31'd0, video_ok}, (n != 4) ? 32'd0 : 32'd1);
    end

    // R5: sweep the valid count of the third line, reference is 10
    for (int k = 8; k <= 12; k++) begin
      resync();
      vid_line(20, 10, 1);
      vid_line(20, 10, 0);
      vid_line(20, k, 0);
      vid_line(20, 10, 0);
      vid_line(20, 10, 1);
      wait_sys(12);
      chk("R5 line data count", {28'd0, pend}, (k != 10) ? 32'h4 : 32'h0);
      chk("R10 irq line data", {31'd0, irq}, (k != 10) ? 32'd1 : 32'd0);
    end

    // R4: address ceiling
    resync();
    wr_addr = 16'd100; wait_sys(12);
    chk("R4 addr equal", {28'd0, pend}, 0);
    wr_addr = 16'd101; wait_sys(12);
    chk("R4 addr over", {28'd0, pend}, 32'h2);
    // R10: masked enable hides irq but not video_ok
    chk_en = 4'b1101; wait_sys(2);
    chk("R10 irq masked", {31'd0, irq}, 0);
    chk("R8 ok low while masked", {31'd0, video_ok}, 0);
    chk_en = 4'hF;
    wr_addr = 16'd0; wait_sys(4);
    clear(4'h2);
    chk("R9 clear addr", {28'd0, pend}, 0);

    // R2 / R7: runaway boundary and disabled
    runaway(3000, 4'hF, 1'b0);
    runaway(3001, 4'hF, 1'b1);
    runaway(3001, 4'b1110, 1'b0);
    resync();

    // R6: clock loss, collision of set and clear
    vid_run = 1'b0; wait_sys(60);
    chk("R6 no loss yet", {28'd0, pend}, 0);
    wait_sys(120);
    chk("R6 loss pend", {28'd0, pend}, 32'h8);
    chk("R10 irq loss", {31'd0, irq}, 1);
    clear(4'h8);
    chk("R9 set wins over clear", {28'd0, pend}, 32'h8);
    chk("R9 ok stays low", {31'd0, video_ok}, 0);
    vid_run = 1'b1; wait_sys(20);
    clear(4'h8);
    chk("R6 loss cleared after restart", {28'd0, pend}, 0);
    chk("R8 ok back", {31'd0, video_ok}, 1);

    // R7: clock loss disabled
    chk_en = 4'b0111;
    vid_run = 1'b0; wait_sys(200);
    chk("R7 loss disabled", {28'd0, pend}, 0);
    chk("R7 ok with loss disabled", {31'd0, video_ok}, 1);
    vid_run = 1'b1; wait_sys(20);
    chk_en = 4'hF;

    // R8: two pending bits, cleared one at a time
    resync();
    wr_addr = 16'd200; wait_sys(12);
    vid_run = 1'b0; wait_sys(150);
    vid_run = 1'b1; wait_sys(20);
    chk("R8 two pending", {28'd0, pend}, 32'hA);
    clear(4'h2);
    chk("R8 one left", {28'd0, pend}, 32'h8);
    chk("R8 ok still low", {31'd0, video_ok}, 0);
    clear(4'h8);
    chk("R8 ok after both", {31'd0, video_ok}, 1);
    wr_addr = 16'd0;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule